// File: doc/BRIEF.md
# Unimplemented Address Response Unit

This block sits beside the address path of a processor core and judges each memory-side or control-flow operation against the implemented address space. Every request carries an operation class, a 64-bit address, a flag saying whether address translation is on, and a speculative flag. One cycle later the unit reports the architectural response as a set of registered outputs. The core then raises a data fault, takes an instruction-address trap, substitutes a constant or a not-a-thing marker for the result, drops the operation, or uses a rewritten address for global purge traffic.

The response depends on the operation class. Ordinary loads, stores and maintenance operations fault. Speculative loads and query operations return forced values. Hint-like operations vanish. Control transfers trap. Global purges are normalized rather than refused. Page walking, TLB storage and the delivery of faults belong to other blocks.

Top module: `uaddr_resp_unit`

## Requirements
- R1: A request with `valid_i` high produces `done_o` high on the following cycle, and the response outputs belong to that request. A cycle with `valid_i` low produces `done_o` low and all four response flags low on the next cycle. After reset all outputs are zero.
- R2: An address is implemented at width W when bits 60 down to W all equal bit W-1. Bits 63:61 are region bits and take no part in the test. W is `VA_W` when `xlat_i` is 1 and `PA_W` when it is 0.
- R3: Operation codes 0 (load, non-speculative), 1 (store), 2 (semaphore), 3 (cache flush), 4 (translate query), 5 (faulting prefetch), 6 (faulting probe) and 7 (mandatory register-stack spill/fill) raise `data_fault_o` for an unimplemented address.
- R4: Code 8 (TLB insert/purge) checks its base address at `VA_W` whatever `xlat_i` holds, and raises `data_fault_o` when that address is unimplemented.
- R5: For code 0 with `spec_i` high and an unimplemented address, the unit sets `force_en_o` with `force_val_o` = 2 (not-a-thing marker) and does not fault. With `spec_i` low the same request faults.
- R6: For an unimplemented address, code 9 (non-faulting probe) forces `force_val_o` = 0 and code 10 (access-key query) forces `force_val_o` = 1, each with `force_en_o` high.
- R7: Code 11 (non-faulting prefetch) and code 12 (eager register-stack operation) set `drop_o` for an unimplemented address and never fault.
- R8: Code 13 (taken branch, taken speculation check or return from interrupt) raises `ia_trap_o` when its target address is unimplemented.
- R9: Code 14 (non-branching last slot) forms the next bundle address by clearing address bits 3:0, adding 16 modulo 2^61 and keeping bits 63:61. It raises `ia_trap_o` when that next address is unimplemented.
- R10: Code 15 (incoming global purge) always checks at `VA_W`. When the address is unimplemented, `addr_o` replaces bits 60:VA_W with copies of bit VA_W-1 and keeps all other bits. No flag is raised.
- R11: Code 16 (outgoing global purge) returns `addr_o` as bits VA_W-1:0 sign-extended to 64 bits. No flag is raised.
- R12: At most one of `data_fault_o`, `ia_trap_o`, `force_en_o` and `drop_o` is high. An implemented address raises none of them. For every code except 15 and 16, `addr_o` equals the request address.
- R13: Codes 17 to 31 are unassigned. They raise no flag and pass the address through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 5 | Operation class code |
| addr_i | input | 64 | Request address |
| xlat_i | input | 1 | Translation enabled |
| spec_i | input | 1 | Speculative request |
| done_o | output | 1 | Response valid, one cycle after the request |
| data_fault_o | output | 1 | Unimplemented data address fault |
| ia_trap_o | output | 1 | Unimplemented instruction address trap |
| force_en_o | output | 1 | Result is replaced by `force_val_o` |
| force_val_o | output | 2 | Forced value: 0 zero, 1 one, 2 not-a-thing |
| drop_o | output | 1 | Operation silently dropped |
| addr_o | output | 64 | Pass-through or normalized address |

## Verification
The bench builds the unit with its defaults, `VA_W` = 51 and `PA_W` = 44. These two widths are far apart, so a single address can be implemented virtually but not physically. This lets the bench show that `xlat_i` picks the width and that TLB and purge classes ignore it. With these widths the edges are easy to write: the largest positive address, the address one above it, the lowest negative address and the address just below it. Bundle rows land exactly on the top bundle of each space, on an unaligned address inside that bundle, and on the 2^61 wrap.

// File: rtl/uaddr_pkg.sv
package uaddr_pkg;
  localparam int ADDR_W = 64;
  localparam int REG_W  = 3;
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD       = 5'd0,
    OP_STORE      = 5'd1,
    OP_SEMA       = 5'd2,
    OP_FLUSH      = 5'd3,
    OP_XLATE_Q    = 5'd4,
    OP_PF_FAULT   = 5'd5,
    OP_PROBE_F    = 5'd6,
    OP_RSE_MAND   = 5'd7,
    OP_TLB_MAINT  = 5'd8,
    OP_PROBE_R    = 5'd9,
    OP_KEY_Q      = 5'd10,
    OP_PF_NF      = 5'd11,
    OP_RSE_EAGER  = 5'd12,
    OP_BRANCH     = 5'd13,
    OP_SLOT_SEQ   = 5'd14,
    OP_GPURGE_IN  = 5'd15,
    OP_GPURGE_OUT = 5'd16
  } op_e;

  typedef enum logic [1:0] {
    FV_ZERO = 2'd0,
    FV_ONE  = 2'd1,
    FV_NAT  = 2'd2
  } fval_e;

  typedef struct packed {
    logic              fault;
    logic              trap;
    logic              force_en;
    fval_e             fval;
    logic              drop;
    logic [ADDR_W-1:0] addr;
  } resp_t;
endpackage

// File: rtl/uaddr_span_chk.sv
// Sign-extension check of the current bundle address and of the next bundle address
module uaddr_span_chk #(
  parameter int W = 51
) (
  input  logic [56:0] win_i,   // address bits 60:4
  output logic        cur_ok_o,
  output logic        nxt_ok_o
);
  localparam int FLD_W = 61 - W + 1;
  localparam int LO    = W - 1 - 4;

  logic [FLD_W-1:0] fld, nfld;
  logic             carry;

  always_comb begin
    fld      = win_i[56:LO];
    carry    = &win_i[LO-1:0];
    nfld     = fld + FLD_W'(carry);
    cur_ok_o = (&fld) | ~(|fld);
    nxt_ok_o = (&nfld) | ~(|nfld);
  end
endmodule

// File: rtl/uaddr_resp_dec.sv
module uaddr_resp_dec
  import uaddr_pkg::*;
#(
  parameter int VA_W = 51
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic              xlat_i,
  input  logic              spec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cur_ok_va_i,
  input  logic              cur_ok_pa_i,
  input  logic              nxt_ok_va_i,
  input  logic              nxt_ok_pa_i,
  output resp_t             resp_o
);
  localparam int TRUNC_W = ADDR_W - REG_W - VA_W;
  localparam int SEXT_W  = ADDR_W - VA_W;

  logic impl, nimpl;

  always_comb begin
    impl   = xlat_i ? cur_ok_va_i : cur_ok_pa_i;
    nimpl  = xlat_i ? nxt_ok_va_i : nxt_ok_pa_i;
    resp_o = '0;
    resp_o.fval = FV_ZERO;
    resp_o.addr = addr_i;
    case (op_e'(op_i))
      OP_LOAD: begin
        if (!impl) begin
          if (spec_i) begin
            resp_o.force_en = 1'b1;
            resp_o.fval     = FV_NAT;
          end else begin
            resp_o.fault = 1'b1;
          end
        end
      end
      OP_STORE, OP_SEMA, OP_FLUSH, OP_XLATE_Q,
      OP_PF_FAULT, OP_PROBE_F, OP_RSE_MAND:
        resp_o.fault = !impl;
      OP_TLB_MAINT:
        resp_o.fault = !cur_ok_va_i;
      OP_PROBE_R: begin
        resp_o.force_en = !impl;
        resp_o.fval     = FV_ZERO;
      end
      OP_KEY_Q: begin
        resp_o.force_en = !impl;
        if (!impl) resp_o.fval = FV_ONE;
      end
      OP_PF_NF, OP_RSE_EAGER:
        resp_o.drop = !impl;
      OP_BRANCH:
        resp_o.trap = !impl;
      OP_SLOT_SEQ:
        resp_o.trap = !nimpl;
      OP_GPURGE_IN: begin
        if (!cur_ok_va_i)
          resp_o.addr[ADDR_W-REG_W-1:VA_W] = {TRUNC_W{addr_i[VA_W-1]}};
      end
      OP_GPURGE_OUT:
        resp_o.addr = {{SEXT_W{addr_i[VA_W-1]}}, addr_i[VA_W-1:0]};
      default: ;
    endcase
  end

  always_comb begin
    a_r12_dec_single: assert ($onehot0({resp_o.fault, resp_o.trap, resp_o.force_en, resp_o.drop}));
  end
endmodule

// File: rtl/uaddr_resp_unit.sv
module uaddr_resp_unit
  import uaddr_pkg::*;
#(
  parameter int VA_W = 51,
  parameter int PA_W = 44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic [63:0]       addr_i,
  input  logic              xlat_i,
  input  logic              spec_i,
  output logic              done_o,
  output logic              data_fault_o,
  output logic              ia_trap_o,
  output logic              force_en_o,
  output logic [1:0]        force_val_o,
  output logic              drop_o,
  output logic [63:0]       addr_o
);
  localparam int TRUNC_W = ADDR_W - REG_W - VA_W;
  localparam int SEXT_W  = ADDR_W - VA_W;

  // index 0: virtual width, index 1: physical width
  logic [1:0] cur_ok, nxt_ok;

  for (genvar g = 0; g < 2; g++) begin : g_width
    localparam int W = (g == 0) ? VA_W : PA_W;
    uaddr_span_chk #(.W(W)) u_chk (
      .win_i    (addr_i[60:4]),
      .cur_ok_o (cur_ok[g]),
      .nxt_ok_o (nxt_ok[g])
    );
  end

  resp_t resp_d, resp_q;
  logic  done_q;

  uaddr_resp_dec #(.VA_W(VA_W)) u_dec (
    .op_i        (op_i),
    .xlat_i      (xlat_i),
    .spec_i      (spec_i),
    .addr_i      (addr_i),
    .cur_ok_va_i (cur_ok[0]),
    .cur_ok_pa_i (cur_ok[1]),
    .nxt_ok_va_i (nxt_ok[0]),
    .nxt_ok_pa_i (nxt_ok[1]),
    .resp_o      (resp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      resp_q <= '0;
    end else begin
      done_q <= valid_i;
      if (valid_i) begin
        resp_q <= resp_d;
      end else begin
        resp_q.fault    <= 1'b0;
        resp_q.trap     <= 1'b0;
        resp_q.force_en <= 1'b0;
        resp_q.fval     <= FV_ZERO;
        resp_q.drop     <= 1'b0;
      end
    end
  end

  assign done_o       = done_q;
  assign data_fault_o = resp_q.fault;
  assign ia_trap_o    = resp_q.trap;
  assign force_en_o   = resp_q.force_en;
  assign force_val_o  = resp_q.fval;
  assign drop_o       = resp_q.drop;
  assign addr_o       = resp_q.addr;

  a_r1_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o && !data_fault_o && !ia_trap_o && !force_en_o && !drop_o);
  a_r12_one_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_fault_o, ia_trap_o, force_en_o, drop_o}));
  a_r5_spec_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_LOAD && spec_i |=> !data_fault_o);
  a_r7_hint_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_PF_NF || op_i == OP_RSE_EAGER) |=> !data_fault_o && !ia_trap_o);
  a_r10_trunc_impl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_GPURGE_IN
    |=> addr_o[ADDR_W-REG_W-1:VA_W] == {TRUNC_W{addr_o[VA_W-1]}} && !data_fault_o);
  a_r11_out_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_GPURGE_OUT |=> addr_o[ADDR_W-1:VA_W] == {SEXT_W{addr_o[VA_W-1]}});
  a_r12_pass_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i != OP_GPURGE_IN && op_i != OP_GPURGE_OUT |=> addr_o == $past(addr_i));
endmodule

// File: tb/tb_uaddr_resp_unit.sv
`timescale 1ns/1ps
module tb_uaddr_resp_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [63:0] addr_i = '0;
  logic        xlat_i = 1'b0;
  logic        spec_i = 1'b0;
  logic        done_o, data_fault_o, ia_trap_o, force_en_o, drop_o;
  logic [1:0]  force_val_o;
  logic [63:0] addr_o;

  always #2.5 clk_i = ~clk_i;

  uaddr_resp_unit dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .addr_i, .xlat_i, .spec_i,
    .done_o, .data_fault_o, .ia_trap_o, .force_en_o, .force_val_o,
    .drop_o, .addr_o
  );

  // edges for VA width 51 and PA width 44
  localparam logic [63:0] VMAX  = 64'h0003_FFFF_FFFF_FFFF;
  localparam logic [63:0] VOVER = 64'h0004_0000_0000_0000;
  localparam logic [63:0] VNEG  = 64'h1FFC_0000_0000_0000;
  localparam logic [63:0] VUND  = 64'h1FFB_FFFF_FFFF_FFFF;
  localparam logic [63:0] PMAX  = 64'h0000_07FF_FFFF_FFFF;
  localparam logic [63:0] POVER = 64'h0000_0800_0000_0000;

  localparam logic [3:0] NONE = 4'b0000, FLT = 4'b1000, TRP = 4'b0100, FRC = 4'b0010, DRP = 4'b0001;

  typedef struct packed {
    logic [4:0]  op;
    logic        xlat;
    logic        spec;
    logic [63:0] addr;
    logic [3:0]  flags;   // fault, trap, force, drop
    logic [1:0]  fval;
    logic [63:0] eaddr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{5'd0,  1'b1, 1'b0, VMAX,  NONE, 2'd0, VMAX,  4'd2},   // R2 in range
    '{5'd0,  1'b1, 1'b0, VOVER, FLT,  2'd0, VOVER, 4'd3},   // R3 load fault
    '{5'd0,  1'b1, 1'b1, VOVER, FRC,  2'd2, VOVER, 4'd5},   // R5 spec -> marker
    '{5'd0,  1'b0, 1'b0, POVER, FLT,  2'd0, POVER, 4'd2},   // R2 physical width
    '{5'd0,  1'b1, 1'b0, POVER, NONE, 2'd0, POVER, 4'd2},   // R2 virtual width
    '{5'd1,  1'b1, 1'b0, VUND,  FLT,  2'd0, VUND,  4'd3},   // R3 store below neg edge
    '{5'd1,  1'b1, 1'b0, VNEG,  NONE, 2'd0, VNEG,  4'd2},   // R2 neg edge
    '{5'd2,  1'b1, 1'b0, 64'hE004_0000_0000_0000, FLT, 2'd0, 64'hE004_0000_0000_0000, 4'd2}, // R2 region bits ignored
    '{5'd2,  1'b1, 1'b0, 64'hE003_FFFF_FFFF_FFFF, NONE, 2'd0, 64'hE003_FFFF_FFFF_FFFF, 4'd2},
    '{5'd3,  1'b0, 1'b0, PMAX,  NONE, 2'd0, PMAX,  4'd3},   // R3 flush
    '{5'd3,  1'b0, 1'b0, POVER, FLT,  2'd0, POVER, 4'd3},
    '{5'd4,  1'b1, 1'b0, VOVER, FLT,  2'd0, VOVER, 4'd3},
    '{5'd5,  1'b1, 1'b1, VOVER, FLT,  2'd0, VOVER, 4'd3},   // R3 spec flag no effect
    '{5'd6,  1'b1, 1'b0, VOVER, FLT,  2'd0, VOVER, 4'd3},
    '{5'd7,  1'b1, 1'b0, VOVER, FLT,  2'd0, VOVER, 4'd3},
    '{5'd8,  1'b0, 1'b0, POVER, NONE, 2'd0, POVER, 4'd4},   // R4 VA width despite xlat=0
    '{5'd8,  1'b0, 1'b0, VOVER, FLT,  2'd0, VOVER, 4'd4},
    '{5'd9,  1'b1, 1'b0, VOVER, FRC,  2'd0, VOVER, 4'd6},   // R6 probe -> 0
    '{5'd9,  1'b1, 1'b0, VMAX,  NONE, 2'd0, VMAX,  4'd6},
    '{5'd10, 1'b1, 1'b0, VOVER, FRC,  2'd1, VOVER, 4'd6},   // R6 key query -> 1
    '{5'd11, 1'b1, 1'b0, VOVER, DRP,  2'd0, VOVER, 4'd7},   // R7
    '{5'd12, 1'b0, 1'b0, POVER, DRP,  2'd0, POVER, 4'd7},
    '{5'd12, 1'b1, 1'b0, VNEG,  NONE, 2'd0, VNEG,  4'd7},
    '{5'd13, 1'b1, 1'b0, VOVER, TRP,  2'd0, VOVER, 4'd8},   // R8
    '{5'd13, 1'b1, 1'b0, VMAX,  NONE, 2'd0, VMAX,  4'd8},
    '{5'd13, 1'b0, 1'b0, POVER, TRP,  2'd0, POVER, 4'd8},
    '{5'd14, 1'b1, 1'b0, 64'h0003_FFFF_FFFF_FFF0, TRP, 2'd0, 64'h0003_FFFF_FFFF_FFF0, 4'd9}, // R9 top bundle
    '{5'd14, 1'b1, 1'b0, 64'h0003_FFFF_FFFF_FFE0, NONE, 2'd0, 64'h0003_FFFF_FFFF_FFE0, 4'd9},
    '{5'd14, 1'b1, 1'b0, 64'h0003_FFFF_FFFF_FFF7, TRP, 2'd0, 64'h0003_FFFF_FFFF_FFF7, 4'd9}, // unaligned
    '{5'd14, 1'b0, 1'b0, 64'h0000_07FF_FFFF_FFF0, TRP, 2'd0, 64'h0000_07FF_FFFF_FFF0, 4'd9},
    '{5'd14, 1'b1, 1'b0, 64'h1FFF_FFFF_FFFF_FFF0, NONE, 2'd0, 64'h1FFF_FFFF_FFFF_FFF0, 4'd9}, // 2^61 wrap
    '{5'd15, 1'b1, 1'b0, 64'h0004_0000_0000_1234, NONE, 2'd0, 64'h1FFC_0000_0000_1234, 4'd10}, // R10
    '{5'd15, 1'b0, 1'b0, POVER, NONE, 2'd0, POVER, 4'd10},
    '{5'd15, 1'b1, 1'b0, 64'h2008_0000_0000_0005, NONE, 2'd0, 64'h2000_0000_0000_0005, 4'd10},
    '{5'd16, 1'b1, 1'b0, VOVER, NONE, 2'd0, 64'hFFFC_0000_0000_0000, 4'd11}, // R11
    '{5'd16, 1'b1, 1'b0, 64'hE003_FFFF_FFFF_FFFF, NONE, 2'd0, VMAX, 4'd11},
    '{5'd20, 1'b1, 1'b1, VOVER, NONE, 2'd0, VOVER, 4'd13},  // R13
    '{5'd31, 1'b0, 1'b0, POVER, NONE, 2'd0, POVER, 4'd13}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input int req, input logic [72:0] got, input logic [72:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d got %h exp %h", req, got, exp);
    end
  endtask

  function automatic logic [72:0] outs();
    return {done_o, data_fault_o, ia_trap_o, force_en_o, drop_o, force_val_o, addr_o};
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    check(1, outs(), 73'd0);                     // R1 reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, outs(), 73'd0);                     // R1 idle after reset
    for (int i = 0; i < NV; i++) begin
      op_i = VECS[i].op; xlat_i = VECS[i].xlat; spec_i = VECS[i].spec;
      addr_i = VECS[i].addr; valid_i = 1'b1;
      @(negedge clk_i);
      check(int'(VECS[i].req), outs(),
            {1'b1, VECS[i].flags, VECS[i].fval, VECS[i].eaddr});
    end
    // R1: unimplemented request with valid low leaves no response
    op_i = 5'd0; xlat_i = 1'b1; spec_i = 1'b0; addr_i = VOVER; valid_i = 1'b0;
    @(negedge clk_i);
    check(1, {done_o, data_fault_o, ia_trap_o, force_en_o, drop_o}, 73'd0);
    // R12: back to back, fault then clean store
    valid_i = 1'b1; op_i = 5'd1; addr_i = VOVER;
    @(negedge clk_i);
    check(12, outs(), {1'b1, FLT, 2'd0, VOVER});
    addr_i = VNEG;
    @(negedge clk_i);
    check(12, outs(), {1'b1, NONE, 2'd0, VNEG});
    valid_i = 1'b0;
    @(negedge clk_i);
    // R1: reset clears outputs
    rst_ni = 1'b0;
    #1;
    check(1, outs(), 73'd0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule